// File: doc/BRIEF.md
# Tagged Command/Data Slave Register Front End

This block sits on the register side of a point-to-point link that has one host and one slave. A bit-level receiver delivers messages of one control bit and one byte each. When the control bit is 0 the byte is data, and it is parked in a holding register. When the control bit is 1 the byte is an instruction, and the block records it and decodes it.

A small instruction set does the rest:

- One pair of codes commits the parked data byte into user register A or user register B.
- A second pair asks the slave to return one of those registers. The reply goes out through a bit-level transmitter as a message with control bit 0.

The link has no collision handling, so the slave never starts a reply on its own. A reply is only offered after a read instruction. An unknown code changes nothing except a one-cycle error strobe.

Top module: `cds_front`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the following outputs are all 0: `hold_byte`, `instr_byte`, `reg_a`, `reg_b`, `tx_valid`, `tx_byte` and `err_pulse`.
- R2: A message with control bit 0 writes its byte into `hold_byte`, visible on the next cycle. A later data byte overwrites it, even if no instruction came in between. Data messages leave `reg_a`, `reg_b` and `instr_byte` unchanged.
- R3: A message with control bit 1 writes its byte into `instr_byte` on the next cycle and leaves `hold_byte` unchanged.
- R4: The instruction code 0x01 copies `hold_byte` into `reg_a`, and 0x02 copies it into `reg_b`, both on the next cycle. `hold_byte` keeps its value after the copy.
- R5: The instruction code 0x10 raises `tx_valid` on the next cycle with `tx_byte` equal to `reg_a` as it was when the instruction arrived. The code 0x11 does the same with `reg_b`. `tx_ctrl` is always 0.
- R6: `tx_valid` rises only in the cycle after a read instruction (0x10 or 0x11) was received.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_byte` hold their values. The cycle after `tx_valid` and `tx_ready` are both 1, `tx_valid` is 0 unless a read instruction arrived in that same cycle.
- R8: Any instruction code other than 0x01, 0x02, 0x10 or 0x11 changes no register and no reply. It raises `err_pulse` for exactly the following cycle.
- R9: A read instruction that arrives while a reply is pending and not being accepted is dropped. The pending reply is unchanged and `err_pulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received message is present this cycle |
| rx_ctrl | input | 1 | Control bit of the message (1 = instruction) |
| rx_byte | input | BW | Byte of the message |
| tx_ready | input | 1 | Transmitter accepts the offered reply |
| tx_valid | output | 1 | Reply message offered |
| tx_ctrl | output | 1 | Control bit of the reply (always 0) |
| tx_byte | output | BW | Reply byte |
| hold_byte | output | BW | Incoming data holding register |
| instr_byte | output | BW | Last instruction byte received |
| reg_a | output | BW | User register A |
| reg_b | output | BW | User register B |
| err_pulse | output | 1 | One-cycle strobe for an unknown instruction |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and the four default instruction codes. Random bytes then hit both the defined codes and the unknown ones.

The random stream is weighted toward the four defined codes. It mixes data, instructions and a sparse `tx_ready`, so replies often stay pending long enough for repeated reads to collide with them (R9).

Directed sequences cover the remaining corners:
- back-to-back data bytes that overwrite each other;
- a commit immediately after a data byte;
- a read in the same cycle as an acceptance.

// File: rtl/cds_front.sv
module cds_front #(
  parameter int BW = 8,
  parameter logic [BW-1:0] OP_LD_A = BW'(8'h01),
  parameter logic [BW-1:0] OP_LD_B = BW'(8'h02),
  parameter logic [BW-1:0] OP_RD_A = BW'(8'h10),
  parameter logic [BW-1:0] OP_RD_B = BW'(8'h11)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_ctrl,
  input  logic [BW-1:0] rx_byte,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic          tx_ctrl,
  output logic [BW-1:0] tx_byte,
  output logic [BW-1:0] hold_byte,
  output logic [BW-1:0] instr_byte,
  output logic [BW-1:0] reg_a,
  output logic [BW-1:0] reg_b,
  output logic          err_pulse
);

  logic is_data, is_cmd, op_lda, op_ldb, op_rda, op_rdb, op_bad, tx_free;

  assign is_data = rx_valid & ~rx_ctrl;
  assign is_cmd  = rx_valid & rx_ctrl;
  assign op_lda  = is_cmd && (rx_byte == OP_LD_A);
  assign op_ldb  = is_cmd && (rx_byte == OP_LD_B);
  assign op_rda  = is_cmd && (rx_byte == OP_RD_A);
  assign op_rdb  = is_cmd && (rx_byte == OP_RD_B);
  assign op_bad  = is_cmd & ~(op_lda | op_ldb | op_rda | op_rdb);
  assign tx_free = ~tx_valid | tx_ready;
  assign tx_ctrl = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_byte  <= '0;
      instr_byte <= '0;
      reg_a      <= '0;
      reg_b      <= '0;
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
      err_pulse  <= 1'b0;
    end else begin
      if (is_data) hold_byte <= rx_byte;
      if (is_cmd) instr_byte <= rx_byte;
      if (op_lda) reg_a <= hold_byte;
      if (op_ldb) reg_b <= hold_byte;
      err_pulse <= op_bad;
      if ((op_rda | op_rdb) && tx_free) begin
        tx_valid <= 1'b1;
        tx_byte  <= op_rda ? reg_a : reg_b;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end

  p_data_to_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ctrl) |=> (hold_byte == $past(rx_byte)) && $stable(reg_a) && $stable(reg_b));

  p_cmd_keeps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ctrl) |=> $stable(hold_byte) && (instr_byte == $past(rx_byte)));

  p_reply_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(rx_valid && rx_ctrl && (rx_byte == OP_RD_A || rx_byte == OP_RD_B)));

  p_reply_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte));

  p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(rx_valid && rx_ctrl) && $stable(reg_a) && $stable(reg_b));

  p_reply_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_ctrl);

endmodule

// File: tb/cds_front_test.sv
module cds_front_test;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ctrl = 1'b0, tx_ready = 1'b0;
  logic [BW-1:0] rx_byte = '0;
  logic tx_valid, tx_ctrl, err_pulse;
  logic [BW-1:0] tx_byte, hold_byte, instr_byte, reg_a, reg_b;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [BW-1:0] m_hold, m_instr, m_a, m_b, m_txb;
  logic m_txv, m_err;

  always #5 clk = ~clk;

  cds_front #(.BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
    .rx_byte(rx_byte), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_ctrl(tx_ctrl), .tx_byte(tx_byte), .hold_byte(hold_byte),
    .instr_byte(instr_byte), .reg_a(reg_a), .reg_b(reg_b), .err_pulse(err_pulse)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [BW-1:0] b);
    return b == 8'h01 || b == 8'h02 || b == 8'h10 || b == 8'h11;
  endfunction

  task automatic compare_all();
    chk("R2", "hold_byte", int'(hold_byte), int'(m_hold));
    chk("R3", "instr_byte", int'(instr_byte), int'(m_instr));
    chk("R4", "reg_a", int'(reg_a), int'(m_a));
    chk("R4", "reg_b", int'(reg_b), int'(m_b));
    chk("R7", "tx_valid", int'(tx_valid), int'(m_txv));
    if (m_txv) chk("R5", "tx_byte", int'(tx_byte), int'(m_txb));
    chk("R5", "tx_ctrl", int'(tx_ctrl), 0);
    chk("R8", "err_pulse", int'(err_pulse), int'(m_err));
  endtask

  task automatic cyc(input logic v, input logic c, input logic [BW-1:0] b, input logic rdy);
    logic [BW-1:0] h, ia, ib;
    logic rd, free;
    rx_valid = v; rx_ctrl = c; rx_byte = b; tx_ready = rdy;
    h = m_hold; ia = m_a; ib = m_b;
    rd = v && c && (b == 8'h10 || b == 8'h11);
    free = !m_txv || rdy;
    if (v && !c) m_hold = b;
    if (v && c) m_instr = b;
    if (v && c && b == 8'h01) m_a = h;
    if (v && c && b == 8'h02) m_b = h;
    m_err = v && c && !is_known(b);
    if (rd && free) begin
      m_txv = 1'b1;
      m_txb = (b == 8'h10) ? ia : ib;
    end else if (rdy) m_txv = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_hold = '0; m_instr = '0; m_a = '0; m_b = '0; m_txb = '0; m_txv = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "tx_valid", int'(tx_valid), 0);
    chk("R1", "regs", int'({hold_byte, instr_byte, reg_a, reg_b}), 0);
    chk("R1", "err_pulse", int'(err_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2 overwrite before any instruction, then R4 commit right after data
    cyc(1, 0, 8'h5A, 0);
    cyc(1, 0, 8'hC3, 0);
    chk("R2", "overwrite", int'(hold_byte), 8'hC3);
    cyc(1, 1, 8'h01, 0);
    chk("R4", "reg_a commit", int'(reg_a), 8'hC3);
    cyc(1, 0, 8'h3C, 0);
    cyc(1, 1, 8'h02, 0);
    chk("R4", "reg_b commit", int'(reg_b), 8'h3C);

    // R5 R7 R9 pending reply, second read dropped
    cyc(1, 1, 8'h10, 0);
    chk("R5", "reply A", int'(tx_byte), 8'hC3);
    cyc(0, 0, 8'h00, 0);
    cyc(1, 1, 8'h11, 0);
    chk("R9", "pending kept", int'(tx_byte), 8'hC3);
    chk("R9", "no error", int'(err_pulse), 0);
    cyc(0, 0, 8'h00, 1);
    chk("R7", "released", int'(tx_valid), 0);

    // R6 no reply without request; R8 unknown code
    cyc(1, 1, 8'h7F, 0);
    chk("R8", "strobe", int'(err_pulse), 1);
    chk("R6", "no reply", int'(tx_valid), 0);
    cyc(0, 0, 8'h00, 0);
    chk("R8", "one cycle", int'(err_pulse), 0);

    // read in same cycle as acceptance
    cyc(1, 1, 8'h11, 0);
    cyc(1, 1, 8'h10, 1);
    chk("R7", "reload on accept", int'(tx_byte), 8'hC3);

    for (int i = 0; i < 4000; i++) begin
      logic v, c, rdy;
      logic [BW-1:0] b;
      int pick;
      v = ($urandom % 4) != 0;
      c = $urandom % 2;
      rdy = ($urandom % 4) == 0;
      pick = $urandom % 6;
      case (pick)
        0: b = 8'h01;
        1: b = 8'h02;
        2: b = 8'h10;
        3: b = 8'h11;
        default: b = BW'($urandom);
      endcase
      cyc(v, c, b, rdy);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule